// File: doc/BRIEF.md
# Delay Line Length Calibration Controller

This block runs the first stage of clock delay-line tuning without software in the loop. It tries the line's unit-delay setting one value at a time, starting at zero and counting upward. For each value it enables the line with its sampler switched on. It points the tap select one step beyond the last delay tap, so the line reports the full length it measured. It then waits for the line to flag that the length word is valid. The controller keeps the first unit value whose length pattern shows exactly one clock period inside the line. From that pattern it takes the highest usable tap, which is the index of its top set bit.

A one-cycle start pulse begins a run. A one-cycle done or fail pulse ends it. Software or a phase-tuning engine then reads the chosen unit and the maximum tap. Whenever the host power state changes, a pulse on the power-change input aborts any run and places the line in bypass, so that the output clock equals the input clock. Reset also places the line in bypass. The controller assumes that the line drops its valid flag once the unit value or the sampler setting changes.

The state machine has seven states:
- CAL_IDLE waits for start.
- CAL_ARM applies the attempt settings and clears the timeout counter.
- CAL_WAIT waits for the flag and latches the length word when it arrives.
- CAL_JUDGE tests the length.
- CAL_NEXT advances the unit value.
- CAL_DONE and CAL_FAIL each pulse their flag for one cycle.

The transitions are:
- CAL_IDLE goes to CAL_ARM on start.
- CAL_ARM goes to CAL_WAIT.
- CAL_WAIT goes to CAL_JUDGE on the flag, or to CAL_NEXT on timeout.
- CAL_JUDGE goes to CAL_DONE on acceptance, otherwise to CAL_NEXT.
- CAL_NEXT goes to CAL_FAIL after the last unit value, otherwise back to CAL_ARM.
- CAL_DONE and CAL_FAIL return to CAL_IDLE.
- A power-change pulse sends every state to CAL_IDLE.

Top module: `dlycal_ctrl`

## Requirements
- R1: After reset the line is in bypass (line_en_o=0, smp_en_o=0), busy_o, done_o and fail_o are 0, and unit_o and maxtap_o are 0.
- R2: A start pulse in idle begins a sweep at unit value 0, and busy_o stays 1 until the cycle of the done or fail pulse. A start pulse while busy_o is 1 has no effect on the sweep or on its result.
- R3: While busy_o is 1, line_en_o=1, smp_en_o=1 and tap_sel_o=12 (the number of delay taps, 11, plus one).
- R4: Between attempts, unit_sel_o increases by exactly one, from 0 up to 127 at most.
- R5: If len_flag_i does not rise within TIMEOUT_CYC cycles of the attempt's wait phase, that unit value is skipped and the sweep continues with the next value.
- R6: A 12-bit length word is accepted only when it is nonzero and bit 11 is clear (a value below 2^11). The values 0, 0x800 and 0xFFF are rejected.
- R7: On acceptance the sweep stops. unit_o equals the unit value under test, and maxtap_o equals the index of the highest set bit of the accepted length word.
- R8: If no value from 0 to 127 is accepted, fail_o pulses. unit_o and maxtap_o are then 0 and the line is left in bypass.
- R9: done_o and fail_o are single-cycle pulses and are never high together.
- R10: A pwr_chg_i pulse in any state puts the line in bypass on the next cycle, drops busy_o, and aborts a running sweep without any done or fail pulse.
- R11: After done, the line stays enabled with the sampler off (line_en_o=1, smp_en_o=0), unit_sel_o holds the chosen unit, and tap_sel_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for a calibration run |
| pwr_chg_i | input | 1 | Host power-state change pulse; forces bypass |
| len_flag_i | input | 1 | Delay line reports that the length word is valid |
| len_word_i | input | 12 | Measured length pattern from the delay line |
| line_en_o | output | 1 | Delay line enable (0 with smp_en_o=0 means bypass) |
| smp_en_o | output | 1 | Length sampler enable |
| unit_sel_o | output | 7 | Unit-delay value applied to the line |
| tap_sel_o | output | 4 | Output tap select |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | One-cycle pulse: unit value accepted |
| fail_o | output | 1 | One-cycle pulse: no unit value accepted |
| unit_o | output | 7 | Chosen unit-delay value |
| maxtap_o | output | 4 | Highest usable tap index |

## Verification
The bench targets the edges of the accept window: length words of 0, exactly 0x800, 0xFFF, 0x7FF and 0x001. A design that compares against the wrong bound or forgets the zero check would lock onto the wrong unit value or report a wrong tap. It also stalls the line on chosen unit values to exercise the timeout. A controller that waits forever would hang, and one that treats the timeout as acceptance would stop early. Further cases are a sweep accepted only at unit 127 and a sweep that runs out after 127, where an off-by-one stop would either miss the last value or wrap around to 0. Finally, the bench sends a second start mid-sweep and power-change pulses both mid-sweep and after completion, which catch a restarted sweep, a late done pulse, or a line left enabled.

// File: rtl/dlycal_pkg.sv
package dlycal_pkg;

    typedef enum logic [2:0] {
        CAL_IDLE,
        CAL_ARM,
        CAL_WAIT,
        CAL_JUDGE,
        CAL_NEXT,
        CAL_DONE,
        CAL_FAIL
    } cal_state_t;

endpackage

// File: rtl/dlycal_timer.sv
// Per-attempt timeout counter: cleared on arm, counts while enabled.
module dlycal_timer #(
    parameter int LIMIT = 1000,
    localparam int CW   = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic expired
);
    logic [CW-1:0] cnt_q;

    assign expired = en && (cnt_q == CW'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (en && !expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R5: the wait window never runs past its limit
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(LIMIT));

endmodule

// File: rtl/dlycal_msb.sv
// Index of the highest set bit of a vector; any_o flags a nonzero vector.
module dlycal_msb #(
    parameter int W     = 12,
    localparam int IW   = $clog2(W)
) (
    input  logic [W-1:0]  vec_i,
    output logic [IW-1:0] idx_o,
    output logic          any_o
);
    always_comb begin
        idx_o = '0;
        any_o = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (vec_i[i]) begin
                idx_o = IW'(i);
                any_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dlycal_ctrl.sv
module dlycal_ctrl
    import dlycal_pkg::*;
#(
    parameter int UNIT_W      = 7,
    parameter int NTAP        = 11,
    parameter int TIMEOUT_CYC = 1000,
    localparam int LEN_W      = NTAP + 1,
    localparam int SEL_W      = $clog2(NTAP + 2),
    localparam int TAP_W      = $clog2(LEN_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              pwr_chg_i,
    input  logic              len_flag_i,
    input  logic [LEN_W-1:0]  len_word_i,
    output logic              line_en_o,
    output logic              smp_en_o,
    output logic [UNIT_W-1:0] unit_sel_o,
    output logic [SEL_W-1:0]  tap_sel_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              fail_o,
    output logic [UNIT_W-1:0] unit_o,
    output logic [TAP_W-1:0]  maxtap_o
);
    localparam logic [UNIT_W-1:0] UNIT_LAST = {UNIT_W{1'b1}};
    localparam logic [SEL_W-1:0]  FULL_SEL  = SEL_W'(NTAP + 1);

    cal_state_t st_q, st_d;

    logic [UNIT_W-1:0] cur_q;
    logic [LEN_W-1:0]  len_q;
    logic [UNIT_W-1:0] unit_q;
    logic [TAP_W-1:0]  tap_q;
    logic              locked_q;

    logic              tmo_hit;
    logic [TAP_W-1:0]  msb_idx;
    logic              len_nz;
    logic              accept;
    logic              last_unit;

    dlycal_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (st_q == CAL_ARM),
        .en      (st_q == CAL_WAIT),
        .expired (tmo_hit)
    );

    dlycal_msb #(.W(LEN_W)) u_msb (
        .vec_i (len_q),
        .idx_o (msb_idx),
        .any_o (len_nz)
    );

    // Accept when nonzero and the top bit (one past the last tap) is clear
    assign accept    = len_nz && !len_q[NTAP];
    assign last_unit = (cur_q == UNIT_LAST);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CAL_IDLE;
        else        st_q <= st_d;
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        if (pwr_chg_i) begin
            st_d = CAL_IDLE;
        end else begin
            unique case (st_q)
                CAL_IDLE:  if (start_i) st_d = CAL_ARM;
                CAL_ARM:   st_d = CAL_WAIT;
                CAL_WAIT: begin
                    if (len_flag_i)   st_d = CAL_JUDGE;
                    else if (tmo_hit) st_d = CAL_NEXT;
                end
                CAL_JUDGE: st_d = accept ? CAL_DONE : CAL_NEXT;
                CAL_NEXT:  st_d = last_unit ? CAL_FAIL : CAL_ARM;
                CAL_DONE:  st_d = CAL_IDLE;
                CAL_FAIL:  st_d = CAL_IDLE;
                default:   st_d = CAL_IDLE;
            endcase
        end
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q    <= '0;
            len_q    <= '0;
            unit_q   <= '0;
            tap_q    <= '0;
            locked_q <= 1'b0;
        end else if (pwr_chg_i) begin
            locked_q <= 1'b0;
        end else begin
            if (st_q == CAL_IDLE && start_i) begin
                cur_q    <= '0;
                unit_q   <= '0;
                tap_q    <= '0;
                locked_q <= 1'b0;
            end
            if (st_q == CAL_WAIT && len_flag_i) begin
                len_q <= len_word_i;
            end
            if (st_q == CAL_JUDGE && accept) begin
                unit_q   <= cur_q;
                tap_q    <= msb_idx;
                locked_q <= 1'b1;
            end
            if (st_q == CAL_NEXT && !last_unit) begin
                cur_q <= cur_q + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        line_en_o  = 1'b0;
        smp_en_o   = 1'b0;
        unit_sel_o = unit_q;
        tap_sel_o  = '0;
        busy_o     = 1'b0;
        done_o     = 1'b0;
        fail_o     = 1'b0;
        unique case (st_q)
            CAL_IDLE: begin
                line_en_o = locked_q;
            end
            CAL_ARM, CAL_WAIT, CAL_JUDGE, CAL_NEXT: begin
                line_en_o  = 1'b1;
                smp_en_o   = 1'b1;
                unit_sel_o = cur_q;
                tap_sel_o  = FULL_SEL;
                busy_o     = 1'b1;
            end
            CAL_DONE: begin
                line_en_o = 1'b1;
                done_o    = 1'b1;
            end
            CAL_FAIL: begin
                fail_o = 1'b1;
            end
            default: begin
                line_en_o = 1'b0;
            end
        endcase
    end

    assign unit_o   = unit_q;
    assign maxtap_o = tap_q;

    // R3: every attempt runs with line and sampler on and the full-length tap
    p_attempt_cfg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (line_en_o && smp_en_o && tap_sel_o == FULL_SEL));

    // R4: the unit value only ever steps up by one during a sweep
    p_unit_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && unit_sel_o != $past(unit_sel_o))
        |-> (unit_sel_o == $past(unit_sel_o) + 1'b1));

    // R6: a completion is only reported for an in-window length word
    p_accept_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (len_q != '0 && !len_q[NTAP] && maxtap_o < TAP_W'(NTAP)));

    // R8: failure only follows the last unit value
    p_fail_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> ($past(unit_sel_o) == UNIT_LAST && !line_en_o));

    // R9: completion flags are exclusive single-cycle pulses
    p_pulse_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && fail_o));
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_fail_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |=> !fail_o);

    // R10: a power-state change puts the line in bypass on the next cycle
    p_pwr_bypass_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_chg_i |=> (!line_en_o && !smp_en_o && !busy_o && !done_o && !fail_o));

endmodule

// File: tb/dlycal_ctrl_bench.sv
module dlycal_ctrl_bench;
    localparam int TMO = 16;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        pwr_chg_i = 1'b0;
    logic        len_flag_i = 1'b0;
    logic [11:0] len_word_i = '0;
    logic        line_en_o, smp_en_o, busy_o, done_o, fail_o;
    logic [6:0]  unit_sel_o, unit_o;
    logic [3:0]  tap_sel_o, maxtap_o;

    int nchk = 0;
    int nerr = 0;
    int mode = 0;
    int ncomp = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    dlycal_ctrl #(.TIMEOUT_CYC(TMO)) u_dlycal_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .pwr_chg_i(pwr_chg_i),
        .len_flag_i(len_flag_i), .len_word_i(len_word_i),
        .line_en_o(line_en_o), .smp_en_o(smp_en_o), .unit_sel_o(unit_sel_o),
        .tap_sel_o(tap_sel_o), .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o),
        .unit_o(unit_o), .maxtap_o(maxtap_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Delay-line model: length patterns per unit value and scenario
    function automatic bit silent(input int m, input int u);
        if (m == 1) return (u == 1);
        if (m == 3) return (u % 2 == 0);
        return 1'b0;
    endfunction

    function automatic logic [11:0] pattern(input int m, input int u);
        case (m)
            0: return (u < 5) ? 12'hFFF : 12'h0FF;
            1: return (u == 0) ? 12'h000 : (u == 2) ? 12'h800 : 12'h7FF;
            2: return 12'h001;
            3: return 12'h800;
            default: return (u < 127) ? 12'hFFF : 12'h030;
        endcase
    endfunction

    logic [6:0] last_u = '0;
    int mcnt = 0;
    always @(posedge clk) begin
        last_u <= unit_sel_o;
        if (!(line_en_o && smp_en_o && tap_sel_o == 4'd12) || unit_sel_o != last_u) begin
            mcnt       <= 0;
            len_flag_i <= 1'b0;
        end else if (mcnt < LAT) begin
            mcnt <= mcnt + 1;
        end else if (!silent(mode, int'(unit_sel_o))) begin
            len_flag_i <= 1'b1;
            len_word_i <= pattern(mode, int'(unit_sel_o));
        end
    end

    // Scoreboard
    typedef struct {
        int    unit;
        int    tap;
        bit    fl;
        string req;
    } exp_t;
    exp_t q[$];
    exp_t mon_e;

    always @(negedge clk) begin
        if (rst_n && (done_o || fail_o)) begin
            ncomp++;
            if (q.size() == 0) begin
                check(1'b0, "R10", "unexpected completion pulse", 1, 0);
            end else begin
                mon_e = q.pop_front();
                check(fail_o == mon_e.fl, mon_e.req, "fail flag", int'(fail_o), int'(mon_e.fl));
                check(int'(unit_o) == mon_e.unit, mon_e.req, "unit_o", int'(unit_o), mon_e.unit);
                check(int'(maxtap_o) == mon_e.tap, mon_e.req, "maxtap_o", int'(maxtap_o), mon_e.tap);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    task automatic pulse_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    task automatic pulse_pwr();
        @(negedge clk) pwr_chg_i = 1'b1;
        @(negedge clk) pwr_chg_i = 1'b0;
    endtask

    task automatic wait_end(input string req);
        int n = 0;
        while (!(done_o || fail_o) && n < 6000) begin
            @(negedge clk);
            n++;
        end
        check(n < 6000, req, "completion seen", n, 0);
        @(negedge clk);
    endtask

    task automatic run(input int m, input int u, input int t, input bit f, input string req);
        exp_t e;
        mode = m;
        e.unit = u; e.tap = t; e.fl = f; e.req = req;
        q.push_back(e);
        pulse_start();
        wait_end(req);
    endtask

    initial begin
        exp_t e;
        int n;
        int c0;
        repeat (3) @(negedge clk);
        // R1: bypass while and after reset
        check(!line_en_o && !smp_en_o, "R1", "bypass in reset", int'(line_en_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !done_o && !fail_o, "R1", "idle flags", int'(busy_o), 0);
        check(unit_o == 0 && maxtap_o == 0, "R1", "result regs", int'(unit_o), 0);

        // Scenario A with a second start mid-sweep (R2, R3, R7, R11)
        mode = 0;
        e.unit = 5; e.tap = 7; e.fl = 1'b0; e.req = "R7";
        q.push_back(e);
        pulse_start();
        @(negedge clk);
        check(busy_o, "R2", "busy after start", int'(busy_o), 1);
        check(unit_sel_o == 0, "R2", "sweep begins at 0", int'(unit_sel_o), 0);
        check(line_en_o && smp_en_o && tap_sel_o == 12, "R3", "attempt tap_sel", int'(tap_sel_o), 12);
        n = 0;
        while (unit_sel_o != 3 && n < 2000) begin @(negedge clk); n++; end
        check(unit_sel_o == 3, "R4", "reached unit 3", int'(unit_sel_o), 3);
        pulse_start();
        @(negedge clk);
        check(unit_sel_o >= 3 && busy_o, "R2", "start while busy ignored", int'(unit_sel_o), 3);
        c0 = ncomp;
        wait_end("R7");
        check(ncomp == c0 + 1, "R2", "single completion", ncomp - c0, 1);
        check(line_en_o && !smp_en_o, "R11", "line on, sampler off", int'(smp_en_o), 0);
        check(unit_sel_o == 5 && tap_sel_o == 0, "R11", "unit held, tap 0", int'(unit_sel_o), 5);
        check(!busy_o, "R2", "busy low after done", int'(busy_o), 0);
        pulse_pwr();
        check(!line_en_o && !smp_en_o, "R10", "bypass after power change", int'(line_en_o), 0);

        // Scenario B: zero, timeout, exactly 2^11, then 0x7FF (R5, R6)
        run(1, 3, 10, 1'b0, "R6");
        // Scenario C: smallest nonzero length at unit 0
        run(2, 0, 0, 1'b0, "R7");
        // Scenario E: only the last unit accepted
        run(4, 127, 5, 1'b0, "R4");
        // Scenario D: no unit accepted, half of them time out
        run(3, 0, 0, 1'b1, "R8");
        check(!line_en_o && !smp_en_o, "R8", "bypass after fail", int'(line_en_o), 0);

        // Abort by power change mid-sweep (R10)
        mode = 0;
        pulse_start();
        repeat (10) @(negedge clk);
        c0 = ncomp;
        pulse_pwr();
        check(!busy_o && !line_en_o && !smp_en_o, "R10", "abort to bypass", int'(busy_o), 0);
        repeat (300) @(negedge clk);
        check(ncomp == c0, "R10", "no completion after abort", ncomp - c0, 0);
        check(q.size() == 0, "R9", "scoreboard drained", q.size(), 0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule